// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches three external interrupt pins and turns their activity into one vectored interrupt request for the processor core. Each pin is first passed through a synchronizer. A detector then matches the pin against its sense setting. Edge-type events are held in a sticky flag until the core acknowledges that source. Level-type events are forwarded while the pin stays low and are not stored.

Pins 0 and 1 have a two-bit sense setting. It selects low level, any edge, falling edge or rising edge. Pin 2 has a one-bit sense setting that selects only the rising or the falling edge. Detection works on the pad level only, so a pin still raises requests when it is being driven as an output.

An 8-bit enable register sits on a simple register bus. The register bits gate each pin. The core's global interrupt flag arrives as an input and gates all pins together. When several sources are active, the one with the lowest vector address is presented. Its fixed vector address is shown alongside the request.

Top module: `extint_ctrl`

## Requirements
- R1: `irq_o` is high only if some pin has a pending event, that pin's enable bit is 1, and `gie_i` is 1. With `gie_i` low, `irq_o` stays low whatever the flags hold.
- R2: Enable register bit 6 gates pin 0, bit 7 gates pin 1 and bit 5 gates pin 2. A cycle with `reg_we_i` high loads bits 7:5 from `reg_wdata_i`. The new value appears on `reg_rdata_o` after that clock edge.
- R3: `reg_rdata_o[4:0]` always reads 0, and writes to those bits are ignored. After reset the whole register reads 0x00 and `irq_o` is low.
- R4: With a sense code of 00, pins 0 and 1 request while the synchronized pin is low. The request drops as soon as the pin is high again, and nothing is remembered.
- R5: Sense codes for pins 0 and 1 are: 01 any edge, 10 falling edge, 11 rising edge. A matching edge sets that pin's sticky flag. An edge that does not match sets nothing.
- R6: `sense2_i` = 1 selects the rising edge on pin 2 and 0 selects the falling edge. Pin 2 never requests on a held level.
- R7: The vector addresses are 0x002 for pin 0, 0x004 for pin 1 and 0x006 for pin 2. When several requests are active at once, the lowest vector address wins. `irq_vec_o` is 0 while `irq_o` is low.
- R8: `irq_ack_i` high while `irq_o` is high clears only the flag of the source being presented. If a new matching edge on that source is seen in the same cycle, the flag stays set.
- R9: Each pin passes through a two-flop synchronizer. After a pin change, a level request shows on `irq_o` after the 2nd rising clock edge, and an edge request after the 3rd.
- R10: An edge flag is set even while its enable bit or `gie_i` is 0. Enabling the pin later presents the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Enable register write strobe |
| reg_wdata_i | input | 8 | Enable register write data |
| reg_rdata_o | output | 8 | Enable register read data |
| pin_i | input | 3 | Asynchronous external interrupt pins |
| sense0_i | input | 2 | Pin 0 sense code |
| sense1_i | input | 2 | Pin 1 sense code |
| sense2_i | input | 1 | Pin 2 edge polarity (1 rising, 0 falling) |
| gie_i | input | 1 | Core global interrupt enable |
| irq_ack_i | input | 1 | Core acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | VEC_W (12) | Vector address of the presented request |

## Verification
The bench uses the default parameters: two synchronizer stages and a 12-bit vector. With two stages, the edge-versus-level latency of R9 can be checked on exact cycles. It also allows an acknowledge to be placed on the very cycle a new edge is detected, which is the collision case of R8. The 12-bit vector width carries the three fixed addresses unchanged, so priority ordering between all three sources can be observed directly at the vector output.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int NUM_PINS  = 3;
  localparam int NUM_LEVEL = 2;   // pins below this index have the four-way sense code

  // sense codes for the four-way pins
  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_ANY  = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
  localparam logic [1:0] SENSE_RISE = 2'b11;

  // enable register bit that gates a given pin
  function automatic int en_bit(input int pin);
    case (pin)
      0:       en_bit = 6;
      1:       en_bit = 7;
      default: en_bit = 5;
    endcase
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0] chain_q [WIDTH];
  logic [STAGES-1:0] chain_d [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES > 1) begin : g_multi
      always_comb chain_d[b] = {chain_q[b][STAGES-2:0], async_i[b]};
    end else begin : g_single
      always_comb chain_d[b] = async_i[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[b] <= '0;
      else         chain_q[b] <= chain_d[b];
    end

    assign sync_o[b] = chain_q[b][STAGES-1];
  end

endmodule

// File: rtl/extint_detect.sv
module extint_detect #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_s_i,    // synchronized pin
  input  logic [1:0] mode_i,
  input  logic       clr_i,      // acknowledge for this source
  output logic       pend_o
);
  import extint_pkg::*;

  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic level_mode;
  logic rise, fall, hit;

  always_comb begin
    level_mode = LEVEL_OK && (mode_i == SENSE_LOW);
    rise       = pin_s_i & ~prev_q;
    fall       = ~pin_s_i & prev_q;
    case (mode_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
    prev_d = pin_s_i;
    if (level_mode)  flag_d = 1'b0;
    else if (hit)    flag_d = 1'b1;   // a fresh edge beats the acknowledge
    else if (clr_i)  flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign pend_o = level_mode ? ~pin_s_i : flag_q;

endmodule

// File: rtl/extint_prio.sv
module extint_prio #(
  parameter int NUM      = 3,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 2,
  parameter int VEC_STEP = 2
) (
  input  logic [NUM-1:0]   req_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NUM-1:0]   clr_o
);

  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx   = IDX_W'(k);
        found = 1'b1;
      end
    end
  end

  assign irq_o = found;
  assign vec_o = found ? VEC_W'(VEC_BASE + VEC_STEP * int'(idx)) : '0;

  for (genvar k = 0; k < NUM; k++) begin : g_clr
    assign clr_o[k] = ack_i & found & (idx == IDX_W'(k));
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [2:0]       pin_i,
  input  logic [1:0]       sense0_i,
  input  logic [1:0]       sense1_i,
  input  logic             sense2_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  import extint_pkg::*;

  localparam int NP = NUM_PINS;

  logic [2:0]    en_q, en_d;          // {bit7, bit6, bit5}
  logic [NP-1:0] pin_s;
  logic [NP-1:0] pend;
  logic [NP-1:0] en_pin;
  logic [NP-1:0] req;
  logic [NP-1:0] clr;
  logic [1:0]    mode [NP];
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata_i[4:0];

  // enable register
  always_comb en_d = reg_we_i ? reg_wdata_i[7:5] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign reg_rdata_o = {en_q, 5'b0};

  // per-pin sense selection
  assign mode[0] = sense0_i;
  assign mode[1] = sense1_i;
  assign mode[2] = {1'b1, sense2_i};   // only falling (10) or rising (11)

  extint_sync #(.WIDTH(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  for (genvar k = 0; k < NP; k++) begin : g_pin
    extint_detect #(.LEVEL_OK(k < NUM_LEVEL)) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_s_i (pin_s[k]),
      .mode_i  (mode[k]),
      .clr_i   (clr[k]),
      .pend_o  (pend[k])
    );
    assign en_pin[k] = reg_rdata_o[en_bit(k)];
    assign req[k]    = pend[k] & en_pin[k] & gie_i;
  end

  extint_prio #(.NUM(NP), .VEC_W(VEC_W), .VEC_BASE(2), .VEC_STEP(2)) u_prio (
    .req_i (req),
    .ack_i (irq_ack_i),
    .irq_o (irq_o),
    .vec_o (irq_vec_o),
    .clr_o (clr)
  );

endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [7:0]       reg_wdata_i,
  input logic [7:0]       reg_rdata_o,
  input logic             gie_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec_o
);

  assert_gie_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  assert_pin2_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_vec_o == VEC_W'(6)) |-> reg_rdata_o[5]);

  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[7:5] == $past(reg_wdata_i[7:5]));

  assert_low_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[4:0] == 5'b0);

  assert_vec_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o == VEC_W'(2) || irq_vec_o == VEC_W'(4) || irq_vec_o == VEC_W'(6)));

  assert_vec_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_vec_o == '0);

endmodule

bind extint_ctrl extint_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .gie_i       (gie_i),
  .irq_o       (irq_o),
  .irq_vec_o   (irq_vec_o)
);

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [2:0]  pin;
  logic [1:0]  s0, s1;
  logic        s2;
  logic        gie;
  logic        ack;
  logic        irq;
  logic [11:0] vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  extint_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pin_i(pin), .sense0_i(s0), .sense1_i(s1),
    .sense2_i(s2), .gie_i(gie), .irq_ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic do_ack;
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  // level-mode table: {p1,p0}[19:18] en{b7,b6,b5}[17:15] gie[14] irq[13] vec[11:0]
  localparam logic [19:0] TBL [9] = '{
    {2'b11, 3'b110, 1'b1, 1'b0, 1'b0, 12'h000},
    {2'b10, 3'b110, 1'b1, 1'b1, 1'b0, 12'h002},
    {2'b01, 3'b110, 1'b1, 1'b1, 1'b0, 12'h004},
    {2'b00, 3'b110, 1'b1, 1'b1, 1'b0, 12'h002},
    {2'b00, 3'b100, 1'b1, 1'b1, 1'b0, 12'h004},
    {2'b00, 3'b110, 1'b0, 1'b0, 1'b0, 12'h000},
    {2'b00, 3'b000, 1'b1, 1'b0, 1'b0, 12'h000},
    {2'b00, 3'b010, 1'b1, 1'b1, 1'b0, 12'h002},
    {2'b10, 3'b100, 1'b1, 1'b0, 1'b0, 12'h000}
  };

  initial begin
    rst_n = 1'b0; we = 1'b0; wdata = '0; pin = '0;
    s0 = 2'b00; s1 = 2'b00; s2 = 1'b0; gie = 1'b0; ack = 1'b0;
    tick(3);
    check("R3 reset rdata", rdata, 8'h00);
    check("R3 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    tick(2);

    wr(8'hFF);
    check("R3 low bits ignored", rdata, 8'hE0);
    wr(8'h40);
    check("R2 bit6 write", rdata, 8'h40);

    // R4/R1/R7 level table
    for (int i = 0; i < 9; i++) begin
      wr({TBL[i][17:15], 5'b0});
      pin[1:0] = TBL[i][19:18];
      gie      = TBL[i][14];
      tick(3);
      check($sformatf("R4 table row %0d irq", i), irq, TBL[i][13]);
      check($sformatf("R7 table row %0d vec", i), vec, TBL[i][11:0]);
    end

    // edge modes
    pin = 3'b000; gie = 1'b1;
    s0 = 2'b11; s1 = 2'b11; s2 = 1'b1;
    wr(8'hE0);
    tick(3);
    check("R5 no edge idle", irq, 1'b0);
    pin[0] = 1'b1;
    tick(2);
    check("R9 edge not before 3rd edge", irq, 1'b0);
    tick(1);
    check("R9 edge at 3rd edge", irq, 1'b1);
    check("R5 rising pin0 vec", vec, 12'h002);
    pin[0] = 1'b0;
    tick(3);
    check("R5 sticky after pin drop", irq, 1'b1);
    do_ack();
    check("R8 ack clears", irq, 1'b0);

    s1 = 2'b10;
    pin[1] = 1'b1;
    tick(3);
    check("R5 falling ignores rise", irq, 1'b0);
    pin[1] = 1'b0;
    tick(3);
    check("R5 falling pin1 vec", vec, 12'h004);
    pin[0] = 1'b1;
    tick(3);
    check("R7 pin0 over pin1", vec, 12'h002);
    do_ack();
    check("R8 only presented cleared", vec, 12'h004);
    do_ack();
    check("R8 pin1 ack", irq, 1'b0);

    s0 = 2'b01;
    pin[0] = 1'b0;
    tick(3);
    check("R5 any edge fall", vec, 12'h002);
    do_ack();
    pin[0] = 1'b1;
    tick(3);
    check("R5 any edge rise", vec, 12'h002);
    do_ack();
    check("R5 any edge ack", irq, 1'b0);

    // pin 2
    pin[2] = 1'b1;
    tick(3);
    check("R6 pin2 rising vec", vec, 12'h006);
    do_ack();
    s2 = 1'b0;
    pin[2] = 1'b0;
    tick(3);
    check("R6 pin2 falling vec", vec, 12'h006);
    do_ack();
    tick(4);
    check("R6 pin2 no level", irq, 1'b0);

    // R10 flag while disabled
    s2 = 1'b1;
    wr(8'h00);
    gie = 1'b0;
    pin[2] = 1'b1;
    tick(3);
    check("R10 disabled no irq", irq, 1'b0);
    wr(8'h20);
    check("R1 gie low masks", irq, 1'b0);
    gie = 1'b1;
    tick(0);
    #1;
    check("R10 held flag presented", vec, 12'h006);
    tick(0);
    do_ack();

    // R8 collision: edge detect in ack cycle
    wr(8'h40);
    s0 = 2'b11;
    pin[0] = 1'b0;
    tick(3);
    pin[0] = 1'b1;
    tick(3);
    check("R8 setup flag", vec, 12'h002);
    pin[0] = 1'b0;
    tick(3);
    pin[0] = 1'b1;
    tick(2);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    check("R8 edge wins over ack", irq, 1'b1);
    do_ack();
    check("R8 later ack", irq, 1'b0);

    // R9 level latency
    wr(8'h80);
    s1 = 2'b00;
    pin[1] = 1'b1;
    tick(3);
    check("R9 level idle", irq, 1'b0);
    pin[1] = 1'b0;
    tick(1);
    check("R9 level not at 1st edge", irq, 1'b0);
    tick(1);
    check("R9 level at 2nd edge", irq, 1'b1);
    pin[1] = 1'b1;
    tick(2);
    check("R4 level released", irq, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule